// File: doc/BRIEF.md
# Receive Frame Queue Status Tracker

This block keeps track of a circular receive queue that lives in buffer memory. It holds a read pointer and a write pointer. The pointers move on increment strobes from the frame data path and from the host reader. When the two pointers are equal the queue is either empty or full. The block tells the two apart by recording which pointer moved last.

From that pointer state and from frame-end events it builds a 16-bit status word. The word holds completion, abort, empty, full/lock and FIFO-overflow flags. A masked OR of the flags drives an interrupt line. When a write fills the queue, the block locks it against further input. The lock clears on one of two unlock commands, or on the first read when auto-unlock is enabled. No data flows through the block: every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure.

Status bits update on the clock edge after the event that causes them. The interrupt line follows the status registers and the mask input with no further delay.

Top module: `rxq_status_top`

## Requirements
- R1: Bit 15 (frame done) sets on `frame_end` or on `frame_abort`. Writing 1 to bit 15 through `stat_wr`/`stat_wdata` clears it. A set in the same cycle as a clear wins.
- R2: A `frame_flush` with no `frame_end` and no `frame_abort` changes no status bit.
- R3: Bit 13 (abort) sets on `frame_abort`, also when `frame_flush` comes in the same cycle. Writing 1 to bit 13 clears it.
- R4: Bit 14 (empty) reads 1 exactly when the queue holds no entries. This is the case after reset and after the read that makes the pointers equal. No status write clears it.
- R5: A `rd_attempt` or `rd_inc` while the queue is empty latches an empty-read request and does not move the read pointer. With `irq_mask[14]`=1 the request raises `irq`. Writing 1 to bit 14 clears the request.
- R6: The write that makes the pointers equal sets bit 12 and `queue_lock`. A `wr_inc` while the queue is locked or full is ignored.
- R7: `cmd_valid` with `cmd_code` 8'h20 or 8'h3F clears the lock. Any other code leaves it unchanged.
- R8: With `auto_unlock_en`=1, the first accepted read increment while locked clears the lock.
- R9: Bit 11 (overflow) sets on `fifo_ovf`, and writing 1 clears it. While it is set, `frame_copy_en` is 0.
- R10: Bits 10 down to 0 always read 0 and never raise `irq`.
- R11: `irq` is the OR over bits 15, 13, 12 and 11 of the status word ANDed with `irq_mask`. Bit 14 takes part through the latched empty-read request. A mask bit of 1 enables that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_inc | input | 1 | Write-pointer increment strobe |
| rd_inc | input | 1 | Read-pointer increment strobe |
| rd_attempt | input | 1 | Host read attempt on the queue |
| frame_end | input | 1 | Frame finished, status and length written |
| frame_abort | input | 1 | Frame in reception aborted |
| frame_flush | input | 1 | Frame in reception flushed |
| fifo_ovf | input | 1 | Receive FIFO overflowed |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| stat_wr | input | 1 | Status write strobe (write 1 to clear) |
| stat_wdata | input | 16 | Status write data |
| irq_mask | input | 16 | Interrupt enables, one per status bit |
| auto_unlock_en | input | 1 | Enable auto-unlock on read |
| status | output | 16 | Status word |
| queue_lock | output | 1 | Queue refuses new input |
| irq | output | 1 | Interrupt request |
| frame_copy_en | output | 1 | Frame-copied indication allowed |

## Verification
The bench builds the block with `PTR_W`=3, which gives an eight-slot queue. Full is then reached in eight writes, so the bench can fill and drain the queue from every one of the eight wrap offsets. At each step it compares the empty and lock bits against an occupancy count it keeps itself. The small size also allows full sweeps of all eight end/abort/flush combinations, of every single-bit interrupt mask, and of several command codes, including the two that unlock.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int STAT_W    = 16;
  localparam int B_DONE    = 15;
  localparam int B_EMPTY   = 14;
  localparam int B_ABORT   = 13;
  localparam int B_LOCK    = 12;
  localparam int B_OVF     = 11;
  localparam int EVT_N     = 4;
  localparam logic [7:0] CMD_UNLOCK_RX  = 8'h20;
  localparam logic [7:0] CMD_UNLOCK_ALL = 8'h3F;

  typedef enum logic [1:0] {
    EV_OVF   = 2'd0,
    EV_ABORT = 2'd1,
    EV_EREQ  = 2'd2,
    EV_DONE  = 2'd3
  } evt_idx_e;
endpackage

// File: rtl/rxq_ptr_track.sv
module rxq_ptr_track #(
  parameter int PTR_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  input  logic rd_req,
  input  logic wr_block,
  output logic is_empty,
  output logic is_full,
  output logic wr_fills,
  output logic rd_taken
);
  logic [PTR_W-1:0] wp, rp;
  logic             last_wr;
  logic             ptr_eq, wr_taken;

  assign ptr_eq   = (wp == rp);
  assign is_empty = ptr_eq & ~last_wr;
  assign is_full  = ptr_eq &  last_wr;
  assign wr_taken = wr_req & ~wr_block & ~is_full;
  assign rd_taken = rd_req & ~is_empty;
  assign wr_fills = wr_taken & ~rd_taken & ((wp + 1'b1) == rp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      last_wr <= 1'b0;
    end else begin
      if (wr_taken) wp <= wp + 1'b1;
      if (rd_taken) rp <= rp + 1'b1;
      if (wr_taken && !rd_taken)      last_wr <= 1'b1;
      else if (rd_taken && !wr_taken) last_wr <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_lock_ctl.sv
module rxq_lock_ctl
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fill_evt,
  input  logic       rd_taken,
  input  logic       auto_en,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  output logic       locked
);
  logic cmd_hit, auto_hit;

  assign cmd_hit  = cmd_valid && (cmd_code == CMD_UNLOCK_RX || cmd_code == CMD_UNLOCK_ALL);
  assign auto_hit = auto_en & rd_taken & locked;

  always_ff @(posedge clk) begin
    if (!rst_n)                    locked <= 1'b0;
    else if (fill_evt)             locked <= 1'b1;
    else if (cmd_hit || auto_hit)  locked <= 1'b0;
  end
endmodule

// File: rtl/rxq_evt_flags.sv
module rxq_evt_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] flag_v
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        flag_v[i] <= 1'b0;
      else if (set_v[i]) flag_v[i] <= 1'b1;
      else if (clr_v[i]) flag_v[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_status_top.sv
module rxq_status_top
  import rxq_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_inc,
  input  logic        rd_inc,
  input  logic        rd_attempt,
  input  logic        frame_end,
  input  logic        frame_abort,
  input  logic        frame_flush,
  input  logic        fifo_ovf,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_code,
  input  logic        stat_wr,
  input  logic [15:0] stat_wdata,
  input  logic [15:0] irq_mask,
  input  logic        auto_unlock_en,
  output logic [15:0] status,
  output logic        queue_lock,
  output logic        irq,
  output logic        frame_copy_en
);
  logic             is_empty, is_full, wr_fills, rd_taken;
  logic [EVT_N-1:0] ev_set, ev_clr, ev_flag;
  logic [STAT_W-1:0] irq_src;

  rxq_ptr_track #(.PTR_W(PTR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_inc),
    .rd_req   (rd_inc),
    .wr_block (queue_lock),
    .is_empty (is_empty),
    .is_full  (is_full),
    .wr_fills (wr_fills),
    .rd_taken (rd_taken)
  );

  rxq_lock_ctl u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_evt  (wr_fills),
    .rd_taken  (rd_taken),
    .auto_en   (auto_unlock_en),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .locked    (queue_lock)
  );

  // frame_flush alone sets nothing; a flush plus abort counts as abort
  always_comb begin
    ev_set = '0;
    ev_set[EV_DONE]  = frame_end | frame_abort;
    ev_set[EV_ABORT] = frame_abort;
    ev_set[EV_EREQ]  = (rd_attempt | rd_inc) & is_empty;
    ev_set[EV_OVF]   = fifo_ovf;
    ev_clr = '0;
    ev_clr[EV_DONE]  = stat_wr & stat_wdata[B_DONE];
    ev_clr[EV_ABORT] = stat_wr & stat_wdata[B_ABORT];
    ev_clr[EV_EREQ]  = stat_wr & stat_wdata[B_EMPTY];
    ev_clr[EV_OVF]   = stat_wr & stat_wdata[B_OVF];
  end

  rxq_evt_flags #(.N(EVT_N)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_v  (ev_set),
    .clr_v  (ev_clr),
    .flag_v (ev_flag)
  );

  always_comb begin
    status          = '0;
    status[B_DONE]  = ev_flag[EV_DONE];
    status[B_EMPTY] = is_empty;
    status[B_ABORT] = ev_flag[EV_ABORT];
    status[B_LOCK]  = queue_lock;
    status[B_OVF]   = ev_flag[EV_OVF];
    irq_src          = status;
    irq_src[B_EMPTY] = ev_flag[EV_EREQ];
  end

  assign irq           = |(irq_src & irq_mask);
  assign frame_copy_en = ~ev_flag[EV_OVF];

  // is_full is used only inside the pointer tracker
  logic unused_full;
  assign unused_full = is_full;
endmodule

module rxq_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_inc,
  input logic        rd_attempt,
  input logic        frame_end,
  input logic        frame_abort,
  input logic        frame_flush,
  input logic        fifo_ovf,
  input logic        cmd_valid,
  input logic [7:0]  cmd_code,
  input logic        stat_wr,
  input logic [15:0] stat_wdata,
  input logic [15:0] irq_mask,
  input logic [15:0] status,
  input logic        queue_lock,
  input logic        irq,
  input logic        frame_copy_en
);
  assert_done_on_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end || frame_abort) |=> status[15]);
  assert_flush_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_flush && !frame_end && !frame_abort && !status[15]) |=> !status[15]);
  assert_abort_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> status[13]);
  assert_empty_read_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_attempt && status[14] && irq_mask[14]) |=> irq);
  assert_lock_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(queue_lock) |-> $past(wr_inc));
  assert_unlock_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_code == 8'h20 || cmd_code == 8'h3F) && !wr_inc) |=> !queue_lock);
  assert_ovf_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status[11] |-> !frame_copy_en);
  assert_ovf_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf |=> status[11]);
endmodule

bind rxq_status_top rxq_status_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_inc(wr_inc), .rd_attempt(rd_attempt),
  .frame_end(frame_end), .frame_abort(frame_abort), .frame_flush(frame_flush),
  .fifo_ovf(fifo_ovf), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .stat_wr(stat_wr), .stat_wdata(stat_wdata), .irq_mask(irq_mask),
  .status(status), .queue_lock(queue_lock), .irq(irq),
  .frame_copy_en(frame_copy_en)
);

// File: tb/test_rxq_status_top.sv
module test_rxq_status_top;
  localparam int PW = 3;
  localparam int DEPTH = 1 << PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_inc = 0, rd_inc = 0, rd_attempt = 0;
  logic frame_end = 0, frame_abort = 0, frame_flush = 0, fifo_ovf = 0;
  logic cmd_valid = 0;
  logic [7:0] cmd_code = '0;
  logic stat_wr = 0;
  logic [15:0] stat_wdata = '0;
  logic [15:0] irq_mask = '0;
  logic auto_unlock_en = 0;
  logic [15:0] status;
  logic queue_lock, irq, frame_copy_en;

  int n_chk = 0, n_err = 0;
  int cnt = 0;
  bit lock_m = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  rxq_status_top #(.PTR_W(PW)) i_rxq_status_top (
    .clk(clk), .rst_n(rst_n), .wr_inc(wr_inc), .rd_inc(rd_inc),
    .rd_attempt(rd_attempt), .frame_end(frame_end), .frame_abort(frame_abort),
    .frame_flush(frame_flush), .fifo_ovf(fifo_ovf), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .irq_mask(irq_mask), .auto_unlock_en(auto_unlock_en), .status(status),
    .queue_lock(queue_lock), .irq(irq), .frame_copy_en(frame_copy_en)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_wr();
    wr_inc = 1; tick(); wr_inc = 0;
    if (!lock_m && cnt < DEPTH) begin
      cnt++;
      if (cnt == DEPTH) lock_m = 1;
    end
  endtask

  task automatic do_rd();
    rd_inc = 1; tick(); rd_inc = 0;
    if (cnt > 0) begin
      cnt--;
      if (lock_m && auto_unlock_en) lock_m = 0;
    end
  endtask

  task automatic do_cmd(logic [7:0] c);
    cmd_valid = 1; cmd_code = c; tick(); cmd_valid = 0; cmd_code = '0;
    if (c == 8'h20 || c == 8'h3F) lock_m = 0;
  endtask

  task automatic w1c(logic [15:0] d);
    stat_wr = 1; stat_wdata = d; tick(); stat_wr = 0; stat_wdata = '0;
  endtask

  task automatic chk_q(string tag);
    chk({tag, " R4 empty"}, 16'(status[14]), 16'(cnt == 0));
    chk({tag, " R6 lock"}, {15'd0, queue_lock}, 16'(lock_m));
    chk({tag, " R6 bit12"}, 16'(status[12]), 16'(lock_m));
    chk({tag, " R10 low bits"}, {5'd0, status[10:0]}, 16'd0);
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finish");
    if (!done_flag) begin
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // reset state
    irq_mask = 16'hFFFF;
    tick();
    chk("R4 reset status", status, 16'h4000);
    chk("R11 reset irq", {15'd0, irq}, 16'd0);
    chk("R9 reset copy_en", {15'd0, frame_copy_en}, 16'd1);
    irq_mask = '0;

    // R5: read while empty does not move the pointer
    do_rd();
    rd_attempt = 1; tick(); rd_attempt = 0;
    do_wr();
    chk_q("R5 no-move");
    do_rd();
    chk_q("R5 back empty");
    w1c(16'h4000);

    // R4/R6/R7: fill and drain from every wrap offset
    for (int off = 0; off < DEPTH; off++) begin
      for (int k = 0; k < DEPTH; k++) begin
        do_wr();
        chk_q("R6 fill");
      end
      do_wr();
      chk_q("R6 write ignored when locked");
      do_cmd((off % 2) ? 8'h3F : 8'h20);
      chk_q("R7 unlock");
      do_wr();
      chk_q("R6 write ignored when full");
      for (int k = 0; k < DEPTH; k++) begin
        do_rd();
        chk_q("R4 drain");
      end
      w1c(16'h4000);
      do_wr();
      do_rd();
      chk_q("R4 rotate");
    end

    // R7: other codes ignored
    for (int k = 0; k < DEPTH; k++) do_wr();
    chk_q("R6 full again");
    begin
      logic [7:0] codes [4] = '{8'h00, 8'h21, 8'h3E, 8'h1F};
      foreach (codes[i]) begin
        do_cmd(codes[i]);
        chk_q("R7 other code ignored");
      end
    end
    do_cmd(8'h3F);
    for (int k = 0; k < DEPTH; k++) do_rd();
    chk_q("R4 drained");

    // R8: auto-unlock
    auto_unlock_en = 1;
    for (int k = 0; k < DEPTH; k++) do_wr();
    chk_q("R8 locked");
    do_rd();
    chk_q("R8 auto unlock");
    do_wr();
    chk_q("R8 relock");
    for (int k = 0; k < DEPTH; k++) do_rd();
    chk_q("R8 drained");
    auto_unlock_en = 0;
    w1c(16'h4000);

    // R1/R2/R3: all end/abort/flush combinations
    for (int c = 0; c < 8; c++) begin
      w1c(16'hFFFF);
      frame_end = c[0]; frame_abort = c[1]; frame_flush = c[2];
      tick();
      frame_end = 0; frame_abort = 0; frame_flush = 0;
      chk("R1 done by combo", 16'(status[15]), 16'(c[0] | c[1]));
      chk("R3 abort by combo", 16'(status[13]), 16'(c[1]));
      if (c == 4) chk("R2 flush only", status, 16'h4000);
    end
    w1c(16'hFFFF);
    chk("R1 R3 cleared", status, 16'h4000);
    // R1: set wins over clear
    frame_end = 1; stat_wr = 1; stat_wdata = 16'h8000; tick();
    frame_end = 0; stat_wr = 0; stat_wdata = '0;
    chk("R1 set wins", 16'(status[15]), 16'd1);
    // R4: writing bit14 leaves empty set
    w1c(16'hFFFF);
    chk("R4 no clear by write", status, 16'h4000);

    // R9
    fifo_ovf = 1; tick(); fifo_ovf = 0;
    chk("R9 ovf bit", 16'(status[11]), 16'd1);
    chk("R9 copy blocked", {15'd0, frame_copy_en}, 16'd0);
    w1c(16'h0800);
    chk("R9 ovf cleared", 16'(status[11]), 16'd0);
    chk("R9 copy allowed", {15'd0, frame_copy_en}, 16'd1);

    // R5: empty-read request
    irq_mask = 16'h4000;
    tick();
    chk("R5 no request no irq", {15'd0, irq}, 16'd0);
    rd_attempt = 1; tick(); rd_attempt = 0;
    chk("R5 request irq", {15'd0, irq}, 16'd1);
    w1c(16'h4000);
    chk("R5 request cleared", {15'd0, irq}, 16'd0);

    // R10/R11: single-bit mask sweep with every source active
    irq_mask = '0;
    rd_attempt = 1; tick(); rd_attempt = 0;
    for (int k = 0; k < DEPTH; k++) do_wr();
    frame_abort = 1; fifo_ovf = 1; tick(); frame_abort = 0; fifo_ovf = 0;
    chk("R11 all flags", status, 16'hB800);
    for (int b = 0; b < 16; b++) begin
      irq_mask = 16'(1) << b;
      #1;
      chk((b < 11) ? "R10 reserved mask" : "R11 mask bit", {15'd0, irq},
          16'(b >= 11));
    end
    irq_mask = '0;
    #1;
    chk("R11 mask zero", {15'd0, irq}, 16'd0);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule